// File: doc/BRIEF.md
# FIFO Programmable Threshold Flag Unit

This block sits beside a dual-clock FIFO. It generates the two threshold warnings: almost-empty in the read clock domain and almost-full in the write clock domain. Each warning compares the occupancy count seen in its own domain against an offset held in a register. There are two such registers. The empty offset sets how close to empty the almost-empty warning fires, and the full offset sets how close to full the almost-full warning fires.

The offsets are programmed through a single active-low program pin. This pin is shared with the FIFO's write-enable and read-enable strobes.

- While the pin is held low, each enabled write clock edge loads the next register in a two-entry rotation: empty, then full, then empty again. The same rotation applies to readback, where each enabled read clock edge places the next register's value on a readback bus.
- Each rotation position survives when the pin is released, so a later session resumes where the last one stopped.
- While the pin is low, the FIFO memory strobes the block hands on are held off.

Top module: `fifo_flag_offsets`

## Requirements
- R1: An asynchronous active-low reset restores both offsets to their parameter defaults. It also points both rotations at the empty offset, clears the readback bus to zero, drives the almost-empty output low and drives the almost-full output high.
- R2: On a write clock edge with the program pin low and write enable low, `din` is stored into the register the write rotation points at. The rotation then advances, so successive loads go to empty, full, empty.
- R3: Raising the program pin between loads does not reset the write rotation. The next session's first load goes to the register after the last one written.
- R4: A write clock edge with the program pin low and write enable high changes neither offset nor the write rotation.
- R5: `fifo_wr` is high exactly when write enable is low and the program pin is high. `fifo_rd` is high exactly when read enable is low and the program pin is high.
- R6: On a read clock edge with the program pin low and read enable low, `rb_data` takes the value of the register the read rotation points at. The read rotation then advances (empty first, then full). At all other edges `rb_data` holds its value.
- R7: `almost_empty_n` is active low. On each read clock edge it is set to 0 when `rd_count` is less than or equal to the empty offset, and to 1 otherwise.
- R8: `almost_full_n` is active low. On each write clock edge it is set to 0 when DEPTH minus `wr_count` is less than or equal to the full offset, and to 1 otherwise.
- R9: A register that has not been loaded since reset keeps its default value (7 for both registers with default parameters).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_n | input | 1 | Offset access select, active low |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| din | input | OW (12) | Low bits of the FIFO input bus, used as offset load data |
| wr_count | input | CW (7) | Occupancy count as seen in the write domain |
| rd_count | input | CW (7) | Occupancy count as seen in the read domain |
| fifo_wr | output | 1 | Qualified memory write strobe |
| fifo_rd | output | 1 | Qualified memory read strobe |
| rb_data | output | OW (12) | Offset readback value |
| almost_empty_n | output | 1 | Almost-empty warning, active low, read domain |
| almost_full_n | output | 1 | Almost-full warning, active low, write domain |

## Verification
The bench targets the following corner cases:

- **Rotation kept across sessions.** A design that reset the rotation whenever the program pin rose would load the empty offset a second time, and a later readback would expose the wrong value in the full slot.
- **No-op cycles.** Program-low cycles without an enable must not advance either rotation. A design that advanced on them would shift every later load and readback by one slot.
- **Threshold boundaries.** Both flags are probed at counts exactly equal to the offset and one step past it. A strict-less-than comparison, or a full comparison made against the count rather than the free space, flips one of those samples.
- **Load on the same edge as a flag update.** A flag sampled on the edge that loads a new offset must still reflect the old offset.
- **Default after reset.** After reset, exactly one register is loaded. The unloaded one must read back its default.

// File: rtl/fflo_pkg.sv
package fflo_pkg;
    // Which offset register a rotation currently addresses
    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    function automatic ofs_sel_e next_sel(input ofs_sel_e cur);
        return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction
endpackage

// File: rtl/fflo_thresh.sv
// Combinational threshold compare: either the count itself (empty side)
// or the free space DEPTH - count (full side) against an offset.
module fflo_thresh #(
    parameter int DEPTH    = 64,
    parameter int CW       = 7,
    parameter int OW       = 12,
    parameter bit FROM_TOP = 1'b0
) (
    input  logic [CW-1:0] count,
    input  logic [OW-1:0] ofs,
    output logic          hit
);
    localparam int XW = ((CW > OW) ? CW : OW) + 1;

    logic [XW-1:0] lhs;

    generate
        if (FROM_TOP) begin : g_free
            always_comb lhs = XW'(DEPTH) - XW'(count);
        end else begin : g_used
            always_comb lhs = XW'(count);
        end
    endgenerate

    always_comb hit = (lhs <= XW'(ofs));
endmodule

// File: rtl/fflo_wr_side.sv
// Write-domain part: both offset registers, the load rotation and the
// almost-full flag.
module fflo_wr_side
    import fflo_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int CW     = 7,
    parameter int OW     = 12,
    parameter int DEF_AE = 7,
    parameter int DEF_AF = 7
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          prog_n,
    input  logic          wr_en_n,
    input  logic [OW-1:0] din,
    input  logic [CW-1:0] wr_count,
    output logic [OW-1:0] ae_ofs,
    output logic [OW-1:0] af_ofs,
    output logic          af_n
);
    typedef struct packed {
        logic [OW-1:0] ae_ofs;
        logic [OW-1:0] af_ofs;
        ofs_sel_e      sel;
        logic          af_n;
    } wr_state_t;

    localparam wr_state_t RST_STATE = '{
        ae_ofs: OW'(DEF_AE),
        af_ofs: OW'(DEF_AF),
        sel:    SEL_EMPTY,
        af_n:   1'b1
    };

    wr_state_t st_q, st_d;
    logic      load_w;
    logic      near_full;

    fflo_thresh #(
        .DEPTH(DEPTH), .CW(CW), .OW(OW), .FROM_TOP(1'b1)
    ) u_full_cmp (
        .count(wr_count),
        .ofs  (st_q.af_ofs),
        .hit  (near_full)
    );

    always_comb begin
        load_w = !prog_n && !wr_en_n;
        st_d   = st_q;
        if (load_w) begin
            if (st_q.sel == SEL_EMPTY) st_d.ae_ofs = din;
            else                       st_d.af_ofs = din;
            st_d.sel = next_sel(st_q.sel);
        end
        st_d.af_n = !near_full;
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign ae_ofs = st_q.ae_ofs;
    assign af_ofs = st_q.af_ofs;
    assign af_n   = st_q.af_n;

    // R2
    load_rotate_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (!prog_n && !wr_en_n) |=> (st_q.sel != $past(st_q.sel)));

    // R4
    idle_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !(!prog_n && !wr_en_n) |=> ($stable(st_q.ae_ofs) && $stable(st_q.af_ofs) && $stable(st_q.sel)));

    // R8
    full_flag_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_count == CW'(DEPTH)) |=> !af_n);
endmodule

// File: rtl/fflo_rd_side.sv
// Read-domain part: readback rotation, readback register and the
// almost-empty flag.
module fflo_rd_side
    import fflo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = 7,
    parameter int OW    = 12
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          prog_n,
    input  logic          rd_en_n,
    input  logic [CW-1:0] rd_count,
    input  logic [OW-1:0] ae_ofs,
    input  logic [OW-1:0] af_ofs,
    output logic [OW-1:0] rb_data,
    output logic          ae_n
);
    typedef struct packed {
        ofs_sel_e      sel;
        logic [OW-1:0] rb;
        logic          ae_n;
    } rd_state_t;

    localparam rd_state_t RST_STATE = '{
        sel:  SEL_EMPTY,
        rb:   '0,
        ae_n: 1'b0
    };

    rd_state_t st_q, st_d;
    logic      peek_r;
    logic      near_empty;

    fflo_thresh #(
        .DEPTH(DEPTH), .CW(CW), .OW(OW), .FROM_TOP(1'b0)
    ) u_empty_cmp (
        .count(rd_count),
        .ofs  (ae_ofs),
        .hit  (near_empty)
    );

    always_comb begin
        peek_r = !prog_n && !rd_en_n;
        st_d   = st_q;
        if (peek_r) begin
            st_d.rb  = (st_q.sel == SEL_EMPTY) ? ae_ofs : af_ofs;
            st_d.sel = next_sel(st_q.sel);
        end
        st_d.ae_n = !near_empty;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign rb_data = st_q.rb;
    assign ae_n    = st_q.ae_n;

    // R6
    peek_rotate_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (!prog_n && !rd_en_n) |=> (st_q.sel != $past(st_q.sel)));

    // R6
    peek_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !(!prog_n && !rd_en_n) |=> $stable(rb_data));

    // R7
    empty_flag_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_count == '0) |=> !ae_n);
endmodule

// File: rtl/fifo_flag_offsets.sv
module fifo_flag_offsets #(
    parameter int DEPTH  = 64,
    parameter int OW     = 12,
    parameter int DEF_AE = 7,
    parameter int DEF_AF = 7,
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          prog_n,
    input  logic          wr_en_n,
    input  logic          rd_en_n,
    input  logic [OW-1:0] din,
    input  logic [CW-1:0] wr_count,
    input  logic [CW-1:0] rd_count,
    output logic          fifo_wr,
    output logic          fifo_rd,
    output logic [OW-1:0] rb_data,
    output logic          almost_empty_n,
    output logic          almost_full_n
);
    logic [OW-1:0] ae_ofs;
    logic [OW-1:0] af_ofs;

    // Memory strobes are suppressed for the whole program session
    assign fifo_wr = !wr_en_n && prog_n;
    assign fifo_rd = !rd_en_n && prog_n;

    fflo_wr_side #(
        .DEPTH(DEPTH), .CW(CW), .OW(OW), .DEF_AE(DEF_AE), .DEF_AF(DEF_AF)
    ) u_wr (
        .wclk    (wclk),
        .rst_n   (rst_n),
        .prog_n  (prog_n),
        .wr_en_n (wr_en_n),
        .din     (din),
        .wr_count(wr_count),
        .ae_ofs  (ae_ofs),
        .af_ofs  (af_ofs),
        .af_n    (almost_full_n)
    );

    fflo_rd_side #(
        .DEPTH(DEPTH), .CW(CW), .OW(OW)
    ) u_rd (
        .rclk    (rclk),
        .rst_n   (rst_n),
        .prog_n  (prog_n),
        .rd_en_n (rd_en_n),
        .rd_count(rd_count),
        .ae_ofs  (ae_ofs),
        .af_ofs  (af_ofs),
        .rb_data (rb_data),
        .ae_n    (almost_empty_n)
    );
endmodule

// File: tb/fifo_flag_offsets_bench.sv
module fifo_flag_offsets_bench;
    localparam int DEPTH = 64;
    localparam int OW    = 12;
    localparam int CW    = 7;

    typedef struct packed {
        logic          prog_n;
        logic          wen_n;
        logic          ren_n;
        logic [OW-1:0] din;
        logic [CW-1:0] wc;
        logic [CW-1:0] rc;
        logic          exp_ae_n;
        logic          exp_af_n;
        logic          rb_chk;
        logic [OW-1:0] exp_rb;
    } vec_t;

    localparam int NV = 19;
    // Expected flags reflect counts and offsets present before the edge.
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b1,1'b1,12'd0, 7'd0, 7'd0,1'b0,1'b1,1'b1,12'd0},  // 0 defaults
        '{1'b1,1'b1,1'b1,12'd0, 7'd57,7'd7,1'b0,1'b0,1'b0,12'd0},  // 1 boundary equal
        '{1'b1,1'b1,1'b1,12'd0, 7'd56,7'd8,1'b1,1'b1,1'b0,12'd0},  // 2 one past
        '{1'b0,1'b0,1'b1,12'd5, 7'd56,7'd8,1'b1,1'b1,1'b0,12'd0},  // 3 R2 load empty=5
        '{1'b1,1'b1,1'b1,12'd0, 7'd56,7'd6,1'b1,1'b1,1'b0,12'd0},  // 4
        '{1'b1,1'b1,1'b1,12'd0, 7'd56,7'd5,1'b0,1'b1,1'b0,12'd0},  // 5
        '{1'b0,1'b0,1'b1,12'd32,7'd56,7'd5,1'b0,1'b1,1'b0,12'd0},  // 6 R2 load full=32
        '{1'b1,1'b1,1'b1,12'd0, 7'd32,7'd5,1'b0,1'b0,1'b0,12'd0},  // 7
        '{1'b1,1'b1,1'b1,12'd0, 7'd31,7'd6,1'b1,1'b1,1'b0,12'd0},  // 8
        '{1'b0,1'b1,1'b1,12'd1, 7'd31,7'd6,1'b1,1'b1,1'b0,12'd0},  // 9 R4 no-op
        '{1'b1,1'b0,1'b1,12'd2, 7'd31,7'd6,1'b1,1'b1,1'b0,12'd0},  // 10 plain write
        '{1'b0,1'b1,1'b0,12'd0, 7'd31,7'd6,1'b1,1'b1,1'b1,12'd5},  // 11 R4 readback empty
        '{1'b0,1'b1,1'b0,12'd0, 7'd31,7'd6,1'b1,1'b1,1'b1,12'd32}, // 12 readback full
        '{1'b0,1'b0,1'b1,12'd3, 7'd31,7'd6,1'b1,1'b1,1'b1,12'd32}, // 13 R2 empty=3, rb holds
        '{1'b1,1'b1,1'b1,12'd0, 7'd31,7'd3,1'b0,1'b1,1'b1,12'd32}, // 14 session ends
        '{1'b0,1'b0,1'b1,12'd16,7'd31,7'd3,1'b0,1'b1,1'b0,12'd0},  // 15 R3 goes to full
        '{1'b1,1'b1,1'b1,12'd0, 7'd48,7'd3,1'b0,1'b0,1'b0,12'd0},  // 16 R3 full=16 active
        '{1'b0,1'b1,1'b0,12'd0, 7'd48,7'd3,1'b0,1'b0,1'b1,12'd3},  // 17
        '{1'b0,1'b1,1'b0,12'd0, 7'd48,7'd3,1'b0,1'b0,1'b1,12'd16}  // 18
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          prog_n, wr_en_n, rd_en_n;
    logic [OW-1:0] din;
    logic [CW-1:0] wr_count, rd_count;
    logic          fifo_wr, fifo_rd;
    logic [OW-1:0] rb_data;
    logic          almost_empty_n, almost_full_n;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    fifo_flag_offsets #(.DEPTH(DEPTH), .OW(OW)) u_fifo_flag_offsets (
        .wclk(clk), .rclk(clk), .rst_n(rst_n),
        .prog_n(prog_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
        .din(din), .wr_count(wr_count), .rd_count(rd_count),
        .fifo_wr(fifo_wr), .fifo_rd(fifo_rd), .rb_data(rb_data),
        .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic p, input logic w, input logic r, input logic [OW-1:0] d);
        prog_n = p; wr_en_n = w; rd_en_n = r; din = d;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 1'b1, 1'b1, '0);
        wr_count = '0; rd_count = '0;
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 ae_n in reset", 32'(almost_empty_n), 32'd0);
        check("R1 af_n in reset", 32'(almost_full_n), 32'd1);
        check("R1 rb_data in reset", 32'(rb_data), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].prog_n, VEC[i].wen_n, VEC[i].ren_n, VEC[i].din);
            wr_count = VEC[i].wc;
            rd_count = VEC[i].rc;
            tick();
            check($sformatf("R7 ae_n vec %0d", i), 32'(almost_empty_n), 32'(VEC[i].exp_ae_n));
            check($sformatf("R8 af_n vec %0d", i), 32'(almost_full_n), 32'(VEC[i].exp_af_n));
            if (VEC[i].rb_chk)
                check($sformatf("R6 rb_data vec %0d", i), 32'(rb_data), 32'(VEC[i].exp_rb));
        end

        // R5 strobe qualification
        drive(1'b1, 1'b0, 1'b0, '0);
        #1;
        check("R5 fifo_wr normal", 32'(fifo_wr), 32'd1);
        check("R5 fifo_rd normal", 32'(fifo_rd), 32'd1);
        drive(1'b0, 1'b0, 1'b0, '0);
        #1;
        check("R5 fifo_wr in session", 32'(fifo_wr), 32'd0);
        check("R5 fifo_rd in session", 32'(fifo_rd), 32'd0);
        drive(1'b1, 1'b1, 1'b1, '0);
        @(negedge clk);

        // R1 reset mid-run restores pointers; R9 unloaded register keeps default
        rst_n = 1'b0;
        #1;
        check("R1 ae_n async reset", 32'(almost_empty_n), 32'd0);
        check("R1 af_n async reset", 32'(almost_full_n), 32'd1);
        check("R1 rb_data async reset", 32'(rb_data), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b1, 12'd9);
        tick();
        drive(1'b0, 1'b1, 1'b0, '0);
        tick();
        check("R1 first load went to empty", 32'(rb_data), 32'd9);
        tick();
        check("R9 full offset default", 32'(rb_data), 32'd7);
        drive(1'b1, 1'b1, 1'b1, '0);
        wr_count = 7'd57;
        tick();
        check("R9 default full threshold", 32'(almost_full_n), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule